// File: doc/BRIEF.md
# Per-Unit Dynamic Clock Gating Controller

This block sits beside the issue stage of a small processor core and produces one clock enable, plus a gated clock, for each execution unit: integer, floating-point, load/store and branch. Each cycle it decodes the operation class on every issue slot, works out which units receive work, and combines that with a small per-unit count of operations still in flight. A unit's clock runs only while it has something to do. Only the clock is stopped, never the supply, so state inside a parked unit is kept.

Automatic gating is controlled by a single enable bit at position 11 of a 32-bit control word. The bit is cleared by the synchronous reset, and while it is clear every unit runs freely. The in-flight counts are maintained whether or not gating is on, so switching gating on while work is outstanding is safe. Software, results and timing cannot see the mechanism: a unit's enable rises combinationally in the same cycle an operation is dispatched to it.

Top module: `ucg_ctrl`

## Requirements
- R1: After reset `cfg_rdata` reads 0. After a write, bit 11 of `cfg_rdata` equals bit 11 of the written word.
- R2: While the gating bit is 0, every bit of `unit_en` is 1, whatever the issue and completion inputs are.
- R3: While gating is on, `unit_en[u]` is 1 in any cycle in which a valid slot carries a class mapped to unit u. The class codes are 3 bits wide. Codes 1 (ALU), 2 (multiply) and 7 (system) map to unit 0, the integer unit. Code 3 (FP) maps to unit 1, the FPU. Codes 4 (load) and 5 (store) map to unit 2, the LSU. Code 6 (branch) maps to unit 3, the BRU. Code 0 (no-op) maps to no unit.
- R4: While gating is on, `unit_en[u]` is 0 when unit u has no dispatch in the current cycle and its in-flight count is zero.
- R5: Each unit's in-flight count rises by the number of dispatches it receives in a cycle and falls by one on each `unit_done[u]` pulse. The unit's enable stays 1 while the count is nonzero, for as many cycles as completion is withheld.
- R6: A `unit_done[u]` pulse that arrives while the unit's count is zero is ignored. The count stays zero, and the unit's later enables behave as if the pulse had never occurred.
- R7: A slot whose `issue_valid` bit is 0 dispatches nothing, whatever class code it carries.
- R8: In-flight counts are tracked while gating is off. When gating is then turned on, units with outstanding work stay enabled until that work completes.
- R9: `unit_gclk[u]` is low while `clk` is low. During the high phase it equals the enable value that was present just before the rising edge.
- R10: Write-data bits other than bit 11 are not stored and read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data (bit 11 = gating enable) |
| cfg_rdata | output | 32 | Control word read data |
| issue_valid | input | SLOTS | Per-slot valid for the current issue group |
| issue_class | input | 3*SLOTS | Per-slot 3-bit operation class, slot s at bits [3s+2:3s] |
| unit_done | input | 4 | Per-unit completion pulse |
| unit_en | output | 4 | Per-unit clock enable (0 INT, 1 FPU, 2 LSU, 3 BRU) |
| unit_gclk | output | 4 | Per-unit gated clock |

## Verification
Assertions check on every cycle that dispatch forces the target unit's enable and that an idle unit with no outstanding work is parked while gating is on. They also check that everything runs while gating is off, that a nonzero count holds until a completion arrives, that a stray completion leaves the count at zero, and that no counter overflows. Only the bench scenarios show the arithmetic of the counts across long mixed issue sequences. They also show the carry-over of outstanding work when gating is switched on, the masking of other control bits, and the high-phase value of each gated clock.

// File: rtl/ucg_pkg.sv
package ucg_pkg;

    localparam int NUM_UNITS = 4;
    localparam int CLS_W     = 3;
    localparam int CTRL_W    = 32;
    localparam int GATE_BIT  = 11;

    typedef enum logic [1:0] {
        U_INT = 2'd0,
        U_FPU = 2'd1,
        U_LSU = 2'd2,
        U_BRU = 2'd3
    } unit_e;

    typedef enum logic [CLS_W-1:0] {
        OP_NOP = 3'd0,
        OP_ALU = 3'd1,
        OP_MUL = 3'd2,
        OP_FP  = 3'd3,
        OP_LD  = 3'd4,
        OP_ST  = 3'd5,
        OP_BR  = 3'd6,
        OP_SYS = 3'd7
    } op_class_e;

    typedef struct packed {
        logic      valid;
        op_class_e cls;
    } issue_slot_t;

    function automatic logic [NUM_UNITS-1:0] unit_onehot(unit_e u);
        logic [NUM_UNITS-1:0] v;
        v = '0;
        v[u] = 1'b1;
        return v;
    endfunction

    // Class to unit-request map; a no-op requests nothing.
    function automatic logic [NUM_UNITS-1:0] class_to_unit(op_class_e c);
        case (c)
            OP_ALU, OP_MUL, OP_SYS: return unit_onehot(U_INT);
            OP_FP:                  return unit_onehot(U_FPU);
            OP_LD, OP_ST:           return unit_onehot(U_LSU);
            OP_BR:                  return unit_onehot(U_BRU);
            default:                return '0;
        endcase
    endfunction

    function automatic logic [CTRL_W-1:0] gate_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        m[GATE_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ucg_issue_decode.sv
module ucg_issue_decode
    import ucg_pkg::*;
#(
    parameter int SLOTS  = 2,
    parameter int DISP_W = 2
) (
    input  logic [SLOTS-1:0]           issue_valid,
    input  logic [SLOTS*CLS_W-1:0]     issue_class,
    output logic [NUM_UNITS*DISP_W-1:0] disp_cnt
);

    issue_slot_t          slot [SLOTS];
    logic [NUM_UNITS-1:0] req  [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot[s].valid = issue_valid[s];
        assign slot[s].cls   = op_class_e'(issue_class[s*CLS_W +: CLS_W]);
        assign req[s]        = slot[s].valid ? class_to_unit(slot[s].cls) : '0;
    end

    // Count how many slots target each unit this cycle.
    always_comb begin
        disp_cnt = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            logic [DISP_W-1:0] acc;
            acc = '0;
            for (int s = 0; s < SLOTS; s++) begin
                acc = acc + DISP_W'(req[s][u]);
            end
            disp_cnt[u*DISP_W +: DISP_W] = acc;
        end
    end

    // R7: an invalid slot never contributes a request
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            if (!issue_valid[s]) begin
                p_invalid_quiet_r7: assert (req[s] == '0);
            end
        end
    end

endmodule

// File: rtl/ucg_inflight.sv
module ucg_inflight #(
    parameter int CNT_W  = 3,
    parameter int DISP_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DISP_W-1:0] inc,
    input  logic              dec,
    output logic [CNT_W-1:0]  cnt,
    output logic              busy
);

    localparam int           EXT_W   = CNT_W + 1;
    localparam logic [EXT_W-1:0] CNT_MAX = EXT_W'((1 << CNT_W) - 1);

    logic             dec_eff;
    logic [CNT_W-1:0] cnt_nxt;

    // A completion against an empty counter is dropped.
    assign dec_eff = dec && (cnt != '0);
    assign cnt_nxt = cnt + CNT_W'(inc) - CNT_W'(dec_eff);
    assign busy    = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cnt} + EXT_W'(inc)) <= (CNT_MAX + EXT_W'(dec_eff)));

    p_hold_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 && !dec) |=> (cnt != '0));

    p_stray_done_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && dec && inc == '0) |=> (cnt == '0));

endmodule

// File: rtl/ucg_clk_latch.sv
module ucg_clk_latch (
    input  logic clk,
    input  logic en_in,
    output logic gclk
);

    logic en_lat;

    // Transparent in the low phase, so the enable is frozen while clk is high.
    always_latch begin
        if (!clk) en_lat = en_in;
    end

    assign gclk = clk & en_lat;

endmodule

// File: rtl/ucg_ctrl.sv
module ucg_ctrl
    import ucg_pkg::*;
#(
    parameter int SLOTS = 2,
    parameter int CNT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [31:0]            cfg_wdata,
    output logic [31:0]            cfg_rdata,
    input  logic [SLOTS-1:0]       issue_valid,
    input  logic [SLOTS*3-1:0]     issue_class,
    input  logic [3:0]             unit_done,
    output logic [3:0]             unit_en,
    output logic [3:0]             unit_gclk
);

    localparam int DISP_W = $clog2(SLOTS + 1);

    logic                        gate_on;
    logic [NUM_UNITS*DISP_W-1:0] disp_cnt;
    logic [DISP_W-1:0]           disp_u [NUM_UNITS];
    logic [CNT_W-1:0]            cnt_u  [NUM_UNITS];
    logic [NUM_UNITS-1:0]        busy_u;

    // Only the gating bit is stored.
    always_ff @(posedge clk) begin
        if (rst)         gate_on <= 1'b0;
        else if (cfg_we) gate_on <= cfg_wdata[GATE_BIT];
    end

    always_comb begin
        cfg_rdata = '0;
        cfg_rdata[GATE_BIT] = gate_on;
    end

    ucg_issue_decode #(
        .SLOTS  (SLOTS),
        .DISP_W (DISP_W)
    ) u_decode (
        .issue_valid (issue_valid),
        .issue_class (issue_class),
        .disp_cnt    (disp_cnt)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        assign disp_u[u] = disp_cnt[u*DISP_W +: DISP_W];

        ucg_inflight #(
            .CNT_W  (CNT_W),
            .DISP_W (DISP_W)
        ) u_flight (
            .clk  (clk),
            .rst  (rst),
            .inc  (disp_u[u]),
            .dec  (unit_done[u]),
            .cnt  (cnt_u[u]),
            .busy (busy_u[u])
        );

        assign unit_en[u] = !gate_on || (disp_u[u] != '0) || busy_u[u];

        ucg_clk_latch u_latch (
            .clk   (clk),
            .en_in (unit_en[u]),
            .gclk  (unit_gclk[u])
        );

        p_dispatch_en_r3: assert property (@(posedge clk) disable iff (rst)
            (disp_u[u] != '0) |-> unit_en[u]);

        p_idle_parked_r4: assert property (@(posedge clk) disable iff (rst)
            (gate_on && disp_u[u] == '0 && cnt_u[u] == '0) |-> !unit_en[u]);
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cfg_rdata == '0));

    p_write_mask_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & gate_mask())));

    p_ungated_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[GATE_BIT] == 1'b0) |-> (&unit_en));

endmodule

// File: tb/ucg_ctrl_test.sv
`timescale 1ns/100ps
module ucg_ctrl_test;

    localparam int SLOTS = 2;
    localparam int CMAX  = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  issue_valid = '0;
    logic [5:0]  issue_class = '0;
    logic [3:0]  unit_done = '0;
    logic [3:0]  unit_en;
    logic [3:0]  unit_gclk;

    int n_chk = 0;
    int n_bad = 0;
    int mcnt [4];
    bit mgate = 1'b0;
    int iter = 0;

    always #2.5 clk = ~clk;

    ucg_ctrl #(.SLOTS(SLOTS), .CNT_W(3)) uut (
        .clk (clk), .rst (rst), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata), .issue_valid (issue_valid),
        .issue_class (issue_class), .unit_done (unit_done),
        .unit_en (unit_en), .unit_gclk (unit_gclk)
    );

    function automatic int unit_of(int c);
        if (c == 1 || c == 2 || c == 7) return 0;
        if (c == 3) return 1;
        if (c == 4 || c == 5) return 2;
        if (c == 6) return 3;
        return -1;
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One issue cycle: drive at negedge, check enables mid-low, gclk mid-high.
    task automatic step(bit v0, int c0, bit v1, int c1, bit [3:0] dn, string tag);
        int disp [4];
        int ex [4];
        for (int u = 0; u < 4; u++) disp[u] = 0;
        if (v0 && unit_of(c0) >= 0) disp[unit_of(c0)]++;
        if (v1 && unit_of(c1) >= 0) disp[unit_of(c1)]++;
        @(negedge clk);
        cfg_we = 1'b0;
        issue_valid = {v1, v0};
        issue_class = {3'(c1), 3'(c0)};
        unit_done = dn;
        #1;
        for (int u = 0; u < 4; u++) begin
            string why;
            ex[u] = (!mgate || disp[u] > 0 || mcnt[u] > 0) ? 1 : 0;
            if (tag != "") why = tag;
            else if (!mgate) why = "R2";
            else if (disp[u] > 0) why = "R3";
            else if (mcnt[u] > 0) why = "R5";
            else why = "R4";
            check($sformatf("%s unit%0d en", why, u), unit_en[u], ex[u]);
        end
        @(posedge clk);
        #1;
        for (int u = 0; u < 4; u++)
            check($sformatf("R9 unit%0d gclk", u), unit_gclk[u], ex[u]);
        for (int u = 0; u < 4; u++) begin
            mcnt[u] = mcnt[u] + disp[u] - ((dn[u] && mcnt[u] > 0) ? 1 : 0);
        end
    endtask

    task automatic write_cfg(logic [31:0] w, string req);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        issue_valid = '0;
        unit_done = '0;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        mgate = w[11];
        @(negedge clk);
        #1;
        check($sformatf("%s cfg_rdata", req), cfg_rdata, {20'b0, w[11], 11'b0});
    endtask

    function automatic bit [3:0] pick_done(int it);
        bit [3:0] d;
        for (int u = 0; u < 4; u++) begin
            if (mcnt[u] == 0) d[u] = ((it % 7) == u);
            else d[u] = (mcnt[u] >= 4) || (((it + u) % 3) != 0);
        end
        return d;
    endfunction

    // Issue a pattern, inserting drain cycles if a counter could overflow.
    task automatic issue(bit v0, int c0, bit v1, int c1, string tag);
        bit fits;
        bit [3:0] d;
        do begin
            int disp [4];
            for (int u = 0; u < 4; u++) disp[u] = 0;
            if (v0 && unit_of(c0) >= 0) disp[unit_of(c0)]++;
            if (v1 && unit_of(c1) >= 0) disp[unit_of(c1)]++;
            d = pick_done(iter);
            fits = 1'b1;
            for (int u = 0; u < 4; u++)
                if (mcnt[u] + disp[u] - ((d[u] && mcnt[u] > 0) ? 1 : 0) > CMAX) fits = 1'b0;
            if (!fits) begin
                bit [3:0] dd;
                for (int u = 0; u < 4; u++) dd[u] = (mcnt[u] > 0);
                step(1'b0, 0, 1'b0, 0, dd, "");
            end
        end while (!fits);
        step(v0, c0, v1, c1, d, tag);
        iter++;
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int u = 0; u < 4; u++) mcnt[u] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 reset cfg_rdata", cfg_rdata, 0);
        check("R2 reset enables", unit_en, 4'hF);
        rst = 1'b0;

        // Gating off: everything runs, counts still tracked (R8)
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                issue(1'b1, a, 1'b1, b, "R2");

        write_cfg(32'hFFFF_F7FF, "R10");
        write_cfg(32'h0000_0805, "R1");

        // Outstanding work from the ungated phase keeps units on (R8)
        step(1'b0, 0, 1'b0, 0, 4'h0, "R8");

        // Full sweep of classes and valid combinations with gating on
        for (int vv = 0; vv < 4; vv++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++)
                    issue(vv[0], a, vv[1], b, (vv != 3 && (a != 0 || b != 0)) ? "" : "");

        // Drain, then everything idle must be parked (R4)
        while (mcnt[0] + mcnt[1] + mcnt[2] + mcnt[3] > 0)
            step(1'b0, 0, 1'b0, 0, {mcnt[3] > 0, mcnt[2] > 0, mcnt[1] > 0, mcnt[0] > 0}, "");
        step(1'b0, 0, 1'b0, 0, 4'h0, "R4");

        // Invalid slots carrying real classes dispatch nothing (R7)
        step(1'b0, 3, 1'b0, 6, 4'h0, "R7");
        step(1'b0, 0, 1'b0, 0, 4'h0, "R7");

        // Multi-cycle FP operation held until completion (R5)
        step(1'b1, 3, 1'b0, 0, 4'h0, "R5");
        repeat (5) step(1'b0, 0, 1'b0, 0, 4'h0, "R5");
        step(1'b0, 0, 1'b0, 0, 4'b0010, "R5");
        step(1'b0, 0, 1'b0, 0, 4'h0, "R5");

        // Stray completions are ignored (R6)
        step(1'b0, 0, 1'b0, 0, 4'hF, "R6");
        step(1'b0, 0, 1'b0, 0, 4'h0, "R6");
        step(1'b1, 4, 1'b0, 0, 4'h0, "R6");
        step(1'b0, 0, 1'b0, 0, 4'b0100, "R6");
        step(1'b0, 0, 1'b0, 0, 4'h0, "R6");

        // Turn gating off again
        write_cfg(32'h0000_0000, "R1");
        step(1'b0, 0, 1'b0, 0, 4'h0, "R2");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule